// File: doc/BRIEF.md
# Frame-Synchronized Camera Capture Gate

This block sits between a parallel image sensor and the write port of a slave FIFO. It samples the sensor's frame-valid, line-valid and pixel bus on the rising edge of its clock input. The integrator feeds that input with the inverted pixel clock, so that the sensor is in effect sampled on the falling edge of its own pixel clock. Line-valid drives the FIFO write strobe at all times. A destination-select output decides whether the written words land in the real data destination or in an unused sink.

A host raises a capture request, which may come from another clock domain and may be a level of any length. The block synchronizes the request and turns it into one pulse, then waits for the next low-to-high transition of frame-valid. That whole frame is steered to the data destination, starting with its first pixel. When frame-valid falls, the select returns to the sink and a one-cycle done flag is raised. A counter gives the number of pixels written during the latest capture.

Top module: `cam_capture_gate`

## Requirements
- R1: While reset is high and in the cycle after it, fifo_wr is 0, fifo_sel is 1 (sink), done is 0 and pix_count is 0.
- R2: fifo_rd and fifo_oe are 0 at all times.
- R3: fifo_wr equals line_in from two clock edges earlier, and fifo_data carries the matching pixel, whether or not a capture is running.
- R4: A capture begins only at a rising edge of frame_in seen after a request. A frame that is already in progress, or that has no request before it, is sent to the sink (fifo_sel = 1), and no count changes.
- R5: During a capture fifo_sel is 0 (data destination), and every pixel that line_in marks in that frame is written once and in order. This includes a first pixel whose line-valid rises together with frame-valid.
- R6: After frame_in falls during a capture, fifo_sel returns to 1 and done is 1 for exactly one cycle, in the same cycle.
- R7: pix_count is cleared when a capture begins and rises by one for each pixel written to the data destination. It holds its value until the next capture begins.
- R8: A request held high for several cycles counts as one request. A request that arrives while a capture is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (inverted sensor pixel clock) |
| rst | input | 1 | Synchronous active-high reset |
| cap_req | input | 1 | Host capture request, asynchronous, active high |
| frame_in | input | 1 | Sensor frame-valid |
| line_in | input | 1 | Sensor line-valid |
| data_in | input | DW | Sensor pixel bus |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_sel | output | 1 | Destination select: 0 data, 1 sink |
| fifo_data | output | DW | FIFO write data |
| fifo_rd | output | 1 | FIFO read enable, held low |
| fifo_oe | output | 1 | FIFO output enable, held low |
| done | output | 1 | One-cycle end-of-capture flag |
| pix_count | output | CW | Pixels written in the latest capture |

## Verification
Sensor inputs pass through one sampling register and one output register. A strobe or pixel therefore appears two edges after it is driven. The bench drives on falling edges and samples 2 ns after each rising edge, and it compares fifo_wr and fifo_data with the line-valid it drove one sample earlier. A request needs three edges to become a pending state, so the bench leaves at least four idle cycles between a request and the frame that is meant to be captured. done and the return of the select to the sink are due two edges after frame-valid falls. Counts and select are read only after the frame's blanking cycles have passed.

// File: rtl/capgate_pkg.sv
package capgate_pkg;

    typedef enum logic [1:0] {
        CG_IDLE = 2'd0,
        CG_PEND = 2'd1,
        CG_CAPT = 2'd2
    } cg_state_e;

    typedef struct packed {
        logic frame;
        logic line;
        logic rise;
    } sns_flags_t;

    function automatic cg_state_e cg_next(input cg_state_e cur, input logic req,
                                          input sns_flags_t f);
        cg_state_e nx;
        nx = cur;
        case (cur)
            CG_IDLE: if (req)      nx = CG_PEND;
            CG_PEND: if (f.rise)   nx = CG_CAPT;
            CG_CAPT: if (!f.frame) nx = CG_IDLE;
            default: nx = CG_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/cg_req_sync.sv
module cg_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], req_async};
            last  <= chain[STAGES-1];
        end
    end

    assign req_pulse = chain[STAGES-1] & ~last;

    // R8: a held request yields a single pulse
    assert_one_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        req_pulse |=> !req_pulse);

endmodule

// File: rtl/cg_sensor_sample.sv
module cg_sensor_sample
    import capgate_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_in,
    input  logic          line_in,
    input  logic [DW-1:0] data_in,
    output sns_flags_t    flags,
    output logic [DW-1:0] data_q
);
    logic f_q, f_prev, l_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q    <= 1'b0;
            f_prev <= 1'b0;
            l_q    <= 1'b0;
            data_q <= '0;
        end else begin
            f_q    <= frame_in;
            f_prev <= f_q;
            l_q    <= line_in;
            data_q <= data_in;
        end
    end

    always_comb begin
        flags.frame = f_q;
        flags.line  = l_q;
        flags.rise  = f_q & ~f_prev;
    end

endmodule

// File: rtl/cg_capture_fsm.sv
module cg_capture_fsm
    import capgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_pulse,
    input  sns_flags_t flags,
    output logic       active,
    output logic       start,
    output logic       finish
);
    cg_state_e st;

    always_ff @(posedge clk) begin
        if (rst) st <= CG_IDLE;
        else     st <= cg_next(st, req_pulse, flags);
    end

    always_comb begin
        start  = (st == CG_PEND) && flags.rise;
        active = start || ((st == CG_CAPT) && flags.frame);
        finish = (st == CG_CAPT) && !flags.frame;
    end

endmodule

// File: rtl/cam_capture_gate.sv
module cam_capture_gate
    import capgate_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CW        = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_req,
    input  logic          frame_in,
    input  logic          line_in,
    input  logic [DW-1:0] data_in,
    output logic          fifo_wr,
    output logic          fifo_sel,
    output logic [DW-1:0] fifo_data,
    output logic          fifo_rd,
    output logic          fifo_oe,
    output logic          done,
    output logic [CW-1:0] pix_count
);
    logic          req_pulse;
    sns_flags_t    flags;
    logic [DW-1:0] data_q;
    logic          active, start, finish;

    cg_req_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst(rst), .req_async(cap_req), .req_pulse(req_pulse)
    );

    cg_sensor_sample #(.DW(DW)) u_samp (
        .clk(clk), .rst(rst), .frame_in(frame_in), .line_in(line_in),
        .data_in(data_in), .flags(flags), .data_q(data_q)
    );

    cg_capture_fsm u_fsm (
        .clk(clk), .rst(rst), .req_pulse(req_pulse), .flags(flags),
        .active(active), .start(start), .finish(finish)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr   <= 1'b0;
            fifo_sel  <= 1'b1;
            fifo_data <= '0;
            done      <= 1'b0;
            pix_count <= '0;
        end else begin
            fifo_wr   <= flags.line;
            fifo_sel  <= ~active;
            fifo_data <= data_q;
            done      <= finish;
            if (start)
                pix_count <= flags.line ? CW'(1) : '0;
            else if (active && flags.line)
                pix_count <= pix_count + CW'(1);
        end
    end

    assign fifo_rd = 1'b0;
    assign fifo_oe = 1'b0;

    // R6: the end flag coincides with the sink select
    assert_done_sel_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> fifo_sel);

    // R6: the end flag lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: the data destination is selected only after a frame rising edge
    assert_arm_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (!fifo_sel && $past(fifo_sel)) |-> $past(flags.rise));

    // R7: each write inside a capture advances the count by one
    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !fifo_sel && $past(!fifo_sel)) |-> pix_count == CW'($past(pix_count) + CW'(1)));

endmodule

// File: tb/sim_cam_capture_gate.sv
module sim_cam_capture_gate;
    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cap_req = 1'b0;
    logic          frame_in = 1'b0;
    logic          line_in = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          fifo_wr, fifo_sel, fifo_rd, fifo_oe, done;
    logic [DW-1:0] fifo_data;
    logic [CW-1:0] pix_count;

    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;
    bit ended = 1'b0;
    logic prev_line = 1'b0;
    logic [DW-1:0] prev_data = '0;
    int cap_frame = 0;
    int cap_idx = 0;
    int disc_cnt = 0;
    int done_cnt = 0;

    always #4 clk = ~clk;

    cam_capture_gate #(.DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .cap_req(cap_req), .frame_in(frame_in),
        .line_in(line_in), .data_in(data_in), .fifo_wr(fifo_wr),
        .fifo_sel(fifo_sel), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .fifo_oe(fifo_oe), .done(done), .pix_count(pix_count)
    );

    function automatic logic [DW-1:0] pix_val(input int id, input int idx);
        return DW'(id * 16 + idx);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            chk(fifo_wr === prev_line, "R3 write strobe", fifo_wr, prev_line);
            if (prev_line)
                chk(fifo_data === prev_data, "R3 data", fifo_data, prev_data);
            chk(fifo_rd === 1'b0 && fifo_oe === 1'b0, "R2 read/oe low", {fifo_rd, fifo_oe}, 0);
            if (fifo_wr && fifo_sel === 1'b0) begin
                chk(fifo_data === pix_val(cap_frame, cap_idx), "R5 pixel order",
                    fifo_data, pix_val(cap_frame, cap_idx));
                cap_idx++;
            end
            if (fifo_wr && fifo_sel === 1'b1) disc_cnt++;
            if (done) begin
                done_cnt++;
                chk(fifo_sel === 1'b1, "R6 sink with done", fifo_sel, 1);
            end
        end
        prev_line = line_in;
        prev_data = data_in;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_req(input int n);
        @(negedge clk);
        cap_req = 1'b1;
        repeat (n) @(negedge clk);
        cap_req = 1'b0;
    endtask

    task automatic send_frame(input int id, input int nl, input int np,
                              input int lead, input int rql);
        int i = 0;
        @(negedge clk);
        frame_in = 1'b1;
        repeat (lead) @(negedge clk);
        for (int l = 0; l < nl; l++) begin
            if (l == rql) cap_req = 1'b1;
            for (int p = 0; p < np; p++) begin
                line_in = 1'b1;
                data_in = pix_val(id, i);
                i++;
                @(negedge clk);
                cap_req = 1'b0;
            end
            line_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        frame_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int id = 0;
        int d0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(fifo_wr === 1'b0, "R1 reset wr", fifo_wr, 0);
        chk(fifo_sel === 1'b1, "R1 reset sel", fifo_sel, 1);
        chk(done === 1'b0, "R1 reset done", done, 0);
        chk(pix_count === '0, "R1 reset count", pix_count, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(fifo_sel === 1'b1 && fifo_wr === 1'b0, "R1 after reset", {fifo_wr, fifo_sel}, 1);
        mon_on = 1'b1;

        // R4: no request, frame goes to the sink
        send_frame(1, 2, 3, 1, -1);
        idle(2);
        chk(cap_idx == 0, "R4 no capture without request", cap_idx, 0);
        chk(disc_cnt == 6, "R3 sink writes", disc_cnt, 6);
        chk(pix_count == 0, "R4 count unchanged", pix_count, 0);
        chk(done_cnt == 0, "R4 no done", done_cnt, 0);

        // R5 R6 R7: sweep geometry and lead-in
        id = 10;
        for (int nl = 1; nl <= 3; nl++)
            for (int np = 1; np <= 4; np++)
                for (int lead = 0; lead <= 1; lead++) begin
                    id++;
                    cap_frame = id;
                    cap_idx = 0;
                    d0 = done_cnt;
                    hold_req(1);
                    idle(4);
                    send_frame(id, nl, np, lead, -1);
                    idle(2);
                    chk(cap_idx == nl * np, "R5 pixels captured", cap_idx, nl * np);
                    chk(pix_count == CW'(nl * np), "R7 pixel count", pix_count, nl * np);
                    chk(done_cnt == d0 + 1, "R6 one done", done_cnt, d0 + 1);
                    chk(fifo_sel === 1'b1, "R6 back to sink", fifo_sel, 1);
                end

        // R4: request arriving mid-frame waits for the next frame
        cap_frame = 51;
        cap_idx = 0;
        send_frame(50, 3, 3, 1, 1);
        idle(2);
        chk(cap_idx == 0, "R4 mid-frame not captured", cap_idx, 0);
        chk(pix_count == 16'd12, "R7 count holds", pix_count, 12);
        send_frame(51, 2, 2, 0, -1);
        idle(2);
        chk(cap_idx == 4, "R4 next frame captured", cap_idx, 4);
        chk(pix_count == 16'd4, "R7 count after pending", pix_count, 4);

        // R8: long request level, request during capture ignored
        cap_frame = 60;
        cap_idx = 0;
        d0 = done_cnt;
        hold_req(6);
        idle(4);
        send_frame(60, 2, 3, 1, 1);
        idle(2);
        chk(cap_idx == 6, "R8 captured once", cap_idx, 6);
        send_frame(61, 2, 2, 1, -1);
        idle(2);
        chk(cap_idx == 6, "R8 in-capture request ignored", cap_idx, 6);
        chk(pix_count == 16'd6, "R8 count holds", pix_count, 6);
        chk(done_cnt == d0 + 1, "R8 single done", done_cnt, d0 + 1);
        chk(fifo_sel === 1'b1, "R8 sink idle", fifo_sel, 1);

        summary();
    end
endmodule